// File: doc/BRIEF.md
# IQ Magnitude Front-End

This block accepts interleaved 8-bit in-phase and quadrature samples from an external radio receiver, together with the radio's own sample clock, and produces a decimated stream of unsigned magnitude values in the core clock domain. The in-phase bus is latched on the rising edge of the sample clock and the quadrature bus on the falling edge. The raw offset-binary codes are converted to two's complement, and each captured pair is handed to the core clock domain through an asynchronous FIFO with Gray-coded pointers.

In the core domain, each channel goes through a first-order high-pass filter that removes its DC offset. An approximate magnitude |I| + |Q| is then formed from the filtered pair, without a multiplier or square root. Every four consecutive magnitudes are averaged into a single output word, so an 8 MHz input rate yields a 2 MHz output rate. A downstream detector consumes `mag_data` whenever `mag_valid` pulses.

Top module: `iq_mag_frontend`

## Requirements
- R1: While reset is asserted and right after it, `mag_valid` is low and `mag_data` is zero.
- R2: The in-phase code is sampled on the rising edge of `smp_clk` and the quadrature code on the following falling edge, and the two form one sample pair. The first two rising edges after reset release only bring the capture domain out of reset and contribute no pair.
- R3: Raw codes are offset binary: raw value r stands for r − 128, so 0x80 is zero, 0x00 is −128 and 0xFF is +127.
- R4: Every captured pair reaches the core domain exactly once and in capture order, provided `clk_core` is faster than `smp_clk`. The FIFO never refuses a write under that condition.
- R5: Each channel is filtered as y[n] = x[n] − x[n−1] + y[n−1] − floor(y[n−1] / 2^DC_SHIFT). Both x[−1] and y[−1] are zero after reset, and a constant input decays towards zero.
- R6: The magnitude of a filtered pair is |yI| + |yQ|, computed without saturation.
- R7: Magnitudes are grouped four at a time, the first group starting with the first pair after reset. Each group produces floor(sum / 4) on `mag_data` with a one-cycle `mag_valid` pulse.
- R8: A group of fewer than four magnitudes produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_core | input | 1 | Core processing clock |
| rst_n | input | 1 | Active-low reset, synchronised inside into both domains |
| smp_clk | input | 1 | Sample clock supplied by the radio |
| smp_i_raw | input | IQ_W | In-phase code, offset binary, sampled on the rising edge |
| smp_q_raw | input | IQ_W | Quadrature code, offset binary, sampled on the falling edge |
| mag_valid | output | 1 | One-cycle pulse per averaged magnitude |
| mag_data | output | IQ_W+DC_SHIFT+3 | Averaged magnitude, unsigned |

## Verification
The bench puts different values on the in-phase and quadrature pins. A design that latched both buses on the same edge, or swapped them, would therefore produce wrong magnitudes as soon as the filter output departs from zero. A constant off-centre input and full-scale alternating codes (0x00 and 0xFF) exercise the filter's sign handling and its floor shift. A filter that rounded toward zero or used a logical shift would drift away from the model within a few samples. The run ends with three leftover pairs: a decimator that flushed a partial group would emit a 51st output. A FIFO that dropped or repeated a pair shifts every later group, so the output count and the values both go wrong.

// File: rtl/iqmag_pkg.sv
// Shared definitions for the IQ magnitude front-end.
// Assumes both channels use the same sample width.
package iqmag_pkg;

    parameter int unsigned IQ_W = 8;

    typedef struct packed {
        logic [IQ_W-1:0] i;
        logic [IQ_W-1:0] q;
    } iq_pair_t;

    // Offset binary to two's complement: invert the top bit.
    function automatic logic [IQ_W-1:0] ob_to_tc(input logic [IQ_W-1:0] raw);
        return {~raw[IQ_W-1], raw[IQ_W-2:0]};
    endfunction

endpackage

// File: rtl/iqmag_capture.sv
// Dual-edge pin capture in the sample clock domain.
// The I code is taken on the rising edge and the Q code on the falling edge.
// A completed pair is presented for writing on the next rising edge.
// Assumes both pin buses are steady around the edge that samples them.
module iqmag_capture
    import iqmag_pkg::*;
(
    input  logic            smp_clk,
    input  logic            rst_s_n,
    input  logic [IQ_W-1:0] raw_i,
    input  logic [IQ_W-1:0] raw_q,
    output logic            wr_en,
    output iq_pair_t        wr_pair
);

    logic [IQ_W-1:0] i_hold;
    logic [IQ_W-1:0] q_hold;
    logic            have_i;

    // Rising edge: latch and convert the in-phase code.
    always_ff @(posedge smp_clk or negedge rst_s_n) begin
        if (!rst_s_n) begin
            i_hold <= '0;
            have_i <= 1'b0;
        end else begin
            i_hold <= ob_to_tc(raw_i);
            have_i <= 1'b1;
        end
    end

    // Falling edge: latch and convert the quadrature code.
    always_ff @(negedge smp_clk or negedge rst_s_n) begin
        if (!rst_s_n) begin
            q_hold <= '0;
        end else begin
            q_hold <= ob_to_tc(raw_q);
        end
    end

    assign wr_en   = have_i;
    assign wr_pair = '{i: i_hold, q: q_hold};

endmodule

// File: rtl/iqmag_cdc_fifo.sv
// Asynchronous FIFO with Gray-coded pointers and multi-flop synchronisers.
// The read side pops whenever the FIFO is not empty and registers the data.
// Assumes AW >= 2. Writes are dropped when full, which cannot happen while
// the read clock outruns the write rate.
module iqmag_cdc_fifo #(
    parameter int W    = 16,
    parameter int AW   = 3,
    parameter int SYNC = 2
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         wr_full,
    input  logic         rclk,
    input  logic         rrst_n,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wbin, wgray, rbin, rgray;
    logic [AW:0]  rgray_s [SYNC];
    logic [AW:0]  wgray_s [SYNC];
    logic         rd_empty;

    function automatic logic [AW:0] to_gray(input logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    // Write pointer advance.
    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_en && !wr_full) begin
            wbin  <= wbin + 1'b1;
            wgray <= to_gray(wbin + 1'b1);
        end
    end

    // Storage write.
    always_ff @(posedge wclk) begin
        if (wr_en && !wr_full) begin
            mem[wbin[AW-1:0]] <= wr_data;
        end
    end

    // Read pointer into the write domain.
    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            for (int s = 0; s < SYNC; s++) rgray_s[s] <= '0;
        end else begin
            rgray_s[0] <= rgray;
            for (int s = 1; s < SYNC; s++) rgray_s[s] <= rgray_s[s-1];
        end
    end

    assign wr_full = (wgray == {~rgray_s[SYNC-1][AW:AW-1], rgray_s[SYNC-1][AW-2:0]});

    // Write pointer into the read domain.
    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            for (int s = 0; s < SYNC; s++) wgray_s[s] <= '0;
        end else begin
            wgray_s[0] <= wgray;
            for (int s = 1; s < SYNC; s++) wgray_s[s] <= wgray_s[s-1];
        end
    end

    assign rd_empty = (rgray == wgray_s[SYNC-1]);

    // Pop one entry per cycle while data is available.
    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= !rd_empty;
            if (!rd_empty) begin
                rd_data <= mem[rbin[AW-1:0]];
                rbin    <= rbin + 1'b1;
                rgray   <= to_gray(rbin + 1'b1);
            end
        end
    end

endmodule

// File: rtl/iqmag_dc_block.sv
// First-order DC-blocking high-pass filter for one channel:
// y = x - x_prev + y_prev - (y_prev >>> K), where the shift is a floor division.
// Assumes OUT_W >= IN_W + K + 2, which keeps the recursion from overflowing.
module iqmag_dc_block #(
    parameter int IN_W  = 8,
    parameter int K     = 4,
    parameter int OUT_W = IN_W + K + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_x,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_y
);

    logic signed [OUT_W-1:0] x_ext, x_prev, y_next;

    assign x_ext  = {{(OUT_W-IN_W){in_x[IN_W-1]}}, in_x};
    assign y_next = x_ext - x_prev + out_y - (out_y >>> K);

    // Advance the filter state on each accepted sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_prev    <= '0;
            out_y     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                x_prev <= x_ext;
                out_y  <= y_next;
            end
        end
    end

endmodule

// File: rtl/iqmag_mag_decim.sv
// |I| + |Q| magnitude followed by an average over 2^D_LOG2 samples.
// The group phase starts at reset; a partial group is held, never flushed.
// Assumes no more than one input per cycle.
module iqmag_mag_decim #(
    parameter int IN_W   = 14,
    parameter int D_LOG2 = 2,
    parameter int MAG_W  = IN_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_i,
    input  logic signed [IN_W-1:0] in_q,
    output logic                   mag_stage_valid,
    output logic                   out_valid,
    output logic [MAG_W-1:0]       out_mag
);

    localparam int ACC_W = MAG_W + D_LOG2;

    logic signed [MAG_W-1:0] ext_i, ext_q;
    logic [MAG_W-1:0]        abs_i, abs_q, mag;
    logic [ACC_W-1:0]        acc, sum_now;
    logic [D_LOG2-1:0]       cnt;

    assign ext_i   = {in_i[IN_W-1], in_i};
    assign ext_q   = {in_q[IN_W-1], in_q};
    assign abs_i   = ext_i[MAG_W-1] ? MAG_W'(-ext_i) : MAG_W'(ext_i);
    assign abs_q   = ext_q[MAG_W-1] ? MAG_W'(-ext_q) : MAG_W'(ext_q);
    assign sum_now = acc + ACC_W'(mag);

    // Register the magnitude of each filtered pair.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mag             <= '0;
            mag_stage_valid <= 1'b0;
        end else begin
            mag_stage_valid <= in_valid;
            if (in_valid) mag <= abs_i + abs_q;
        end
    end

    // Accumulate a group and emit its average on the last member.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc       <= '0;
            cnt       <= '0;
            out_valid <= 1'b0;
            out_mag   <= '0;
        end else begin
            out_valid <= 1'b0;
            if (mag_stage_valid) begin
                cnt <= cnt + 1'b1;
                if (&cnt) begin
                    acc       <= '0;
                    out_mag   <= sum_now[ACC_W-1:D_LOG2];
                    out_valid <= 1'b1;
                end else begin
                    acc <= sum_now;
                end
            end
        end
    end

endmodule

// File: rtl/iq_mag_frontend.sv
// Top of the IQ magnitude front-end: reset synchronisers, dual-edge capture,
// clock-domain crossing, per-channel DC block, magnitude and decimation.
// Assumes clk_core runs faster than smp_clk.
module iq_mag_frontend
    import iqmag_pkg::*;
#(
    parameter int DC_SHIFT  = 4,
    parameter int FIFO_AW   = 3,
    parameter int SYNC_N    = 2,
    parameter int DEC_LOG2  = 2
) (
    input  logic                        clk_core,
    input  logic                        rst_n,
    input  logic                        smp_clk,
    input  logic [IQ_W-1:0]             smp_i_raw,
    input  logic [IQ_W-1:0]             smp_q_raw,
    output logic                        mag_valid,
    output logic [IQ_W+DC_SHIFT+2:0]    mag_data
);

    localparam int Y_W   = IQ_W + DC_SHIFT + 2;
    localparam int PAIR_W = $bits(iq_pair_t);

    logic [1:0]              rs_smp, rs_core;
    logic                    rst_s_n, rst_c_n;
    logic                    fifo_wr_en, fifo_full, fifo_rd_valid;
    iq_pair_t                cap_pair, rd_pair;
    logic signed [IQ_W-1:0]  ch_x [2];
    logic signed [Y_W-1:0]   ch_y [2];
    logic                    ch_v [2];
    logic                    dc_valid, mag_stage_valid;

    // Reset release synchronised to the sample clock.
    always_ff @(posedge smp_clk or negedge rst_n) begin
        if (!rst_n) rs_smp <= '0;
        else        rs_smp <= {rs_smp[0], 1'b1};
    end
    assign rst_s_n = rs_smp[1];

    // Reset release synchronised to the core clock.
    always_ff @(posedge clk_core or negedge rst_n) begin
        if (!rst_n) rs_core <= '0;
        else        rs_core <= {rs_core[0], 1'b1};
    end
    assign rst_c_n = rs_core[1];

    iqmag_capture u_capture (
        .smp_clk (smp_clk),
        .rst_s_n (rst_s_n),
        .raw_i   (smp_i_raw),
        .raw_q   (smp_q_raw),
        .wr_en   (fifo_wr_en),
        .wr_pair (cap_pair)
    );

    iqmag_cdc_fifo #(.W(PAIR_W), .AW(FIFO_AW), .SYNC(SYNC_N)) u_fifo (
        .wclk     (smp_clk),
        .wrst_n   (rst_s_n),
        .wr_en    (fifo_wr_en),
        .wr_data  (cap_pair),
        .wr_full  (fifo_full),
        .rclk     (clk_core),
        .rrst_n   (rst_c_n),
        .rd_valid (fifo_rd_valid),
        .rd_data  (rd_pair)
    );

    assign ch_x[0] = $signed(rd_pair.i);
    assign ch_x[1] = $signed(rd_pair.q);

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        iqmag_dc_block #(.IN_W(IQ_W), .K(DC_SHIFT), .OUT_W(Y_W)) u_dc (
            .clk       (clk_core),
            .rst_n     (rst_c_n),
            .in_valid  (fifo_rd_valid),
            .in_x      (ch_x[ch]),
            .out_valid (ch_v[ch]),
            .out_y     (ch_y[ch])
        );
    end

    assign dc_valid = ch_v[0] & ch_v[1];

    iqmag_mag_decim #(.IN_W(Y_W), .D_LOG2(DEC_LOG2), .MAG_W(Y_W + 1)) u_decim (
        .clk             (clk_core),
        .rst_n           (rst_c_n),
        .in_valid        (dc_valid),
        .in_i            (ch_y[0]),
        .in_q            (ch_y[1]),
        .mag_stage_valid (mag_stage_valid),
        .out_valid       (mag_valid),
        .out_mag         (mag_data)
    );

endmodule

// File: rtl/iq_mag_frontend_chk.sv
// Property checker for iq_mag_frontend, attached with bind.
// Observes the reset state, the FIFO write side and the valid chain.
module iq_mag_frontend_chk #(
    parameter int MAG_W = 15
) (
    input logic             clk_core,
    input logic             rst_c_n,
    input logic             smp_clk,
    input logic             rst_s_n,
    input logic             fifo_wr_en,
    input logic             fifo_full,
    input logic             fifo_rd_valid,
    input logic             dc_valid,
    input logic             mag_stage_valid,
    input logic             mag_valid,
    input logic [MAG_W-1:0] mag_data
);

    // R1: outputs stay quiet while the core domain is in reset.
    always @(posedge clk_core) begin
        if (rst_c_n == 1'b0) begin
            p_quiet_in_reset_r1: assert (!mag_valid && mag_data == '0)
                else $error("p_quiet_in_reset_r1");
        end
    end

    // R4: the capture side never writes into a full FIFO.
    p_no_overflow_r4: assert property (@(posedge smp_clk) disable iff (!rst_s_n)
        fifo_wr_en |-> !fifo_full);

    // R5: a filtered sample follows one cycle after a FIFO pop.
    p_dc_after_pop_r5: assert property (@(posedge clk_core) disable iff (!rst_c_n)
        dc_valid |-> $past(fifo_rd_valid));

    // R7: an averaged output follows a magnitude stage result.
    p_out_after_mag_r7: assert property (@(posedge clk_core) disable iff (!rst_c_n)
        mag_valid |-> $past(mag_stage_valid));

    // R7: the output valid is a single-cycle pulse.
    p_single_pulse_r7: assert property (@(posedge clk_core) disable iff (!rst_c_n)
        mag_valid |=> !mag_valid);

endmodule

bind iq_mag_frontend iq_mag_frontend_chk #(.MAG_W(IQ_W + DC_SHIFT + 3)) u_chk (
    .clk_core        (clk_core),
    .rst_c_n         (rst_c_n),
    .smp_clk         (smp_clk),
    .rst_s_n         (rst_s_n),
    .fifo_wr_en      (fifo_wr_en),
    .fifo_full       (fifo_full),
    .fifo_rd_valid   (fifo_rd_valid),
    .dc_valid        (dc_valid),
    .mag_stage_valid (mag_stage_valid),
    .mag_valid       (mag_valid),
    .mag_data        (mag_data)
);

// File: tb/iq_mag_frontend_bench.sv
// Self-checking bench: a behavioural model turns the pin stimulus into the
// expected output stream, and every core clock the outputs are compared.
module iq_mag_frontend_bench;

    localparam int IQW = 8;
    localparam int K   = 4;
    localparam int MW  = IQW + K + 3;

    logic          clk_core = 1'b0;
    logic          rst_n    = 1'b0;
    logic          smp_clk  = 1'b0;
    logic [IQW-1:0] pin_i   = 8'h80;
    logic [IQW-1:0] pin_q   = 8'h80;
    logic          mag_valid;
    logic [MW-1:0] mag_data;

    int checks = 0;
    int fails  = 0;
    int seen   = 0;
    int n_expected = 0;
    int exp_q[$];
    int si[$];
    int sq[$];

    always #5 clk_core = ~clk_core;

    iq_mag_frontend #(.DC_SHIFT(K)) u_iq_mag_frontend (
        .clk_core  (clk_core),
        .rst_n     (rst_n),
        .smp_clk   (smp_clk),
        .smp_i_raw (pin_i),
        .smp_q_raw (pin_q),
        .mag_valid (mag_valid),
        .mag_data  (mag_data)
    );

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Model of R3, R5, R6, R7: offset decode, high-pass, |I|+|Q|, average of 4.
    task automatic build_expected();
        int xi_p = 0, yi_p = 0, xq_p = 0, yq_p = 0;
        int acc = 0, n = 0;
        for (int k = 0; k < si.size(); k++) begin
            int xi = si[k] - 128;
            int xq = sq[k] - 128;
            int yi = xi - xi_p + yi_p - (yi_p >>> K);
            int yq = xq - xq_p + yq_p - (yq_p >>> K);
            xi_p = xi; yi_p = yi; xq_p = xq; yq_p = yq;
            acc += iabs(yi) + iabs(yq);
            n++;
            if (n == 4) begin
                exp_q.push_back(acc / 4);
                acc = 0;
                n = 0;
            end
        end
        n_expected = exp_q.size();
    endtask

    // R2: I set up before the rising edge, Q before the falling edge.
    task automatic send_pair(input int ri, input int rq);
        pin_i = ri[IQW-1:0];
        #30 smp_clk = 1'b1;
        #30 pin_q = rq[IQW-1:0];
        #30 smp_clk = 1'b0;
        #30;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Compare every output pulse against the model, away from the clock edge.
    always @(negedge clk_core) begin
        if (rst_n && mag_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R8 unexpected output %0d: got %0d expected none", seen, mag_data);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(mag_data) != e) begin
                    fails++;
                    $display("FAIL R2 R3 R4 R5 R6 R7 output %0d: got %0d expected %0d",
                             seen, mag_data, e);
                end
            end
            seen++;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk_core);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // Constant off-centre level: DC step that must decay (R5).
        for (int k = 0; k < 40; k++) begin si.push_back(8'hA0); sq.push_back(8'h60); end
        // Full-scale alternation, including 0x00 = -128 (R3, R5).
        for (int k = 0; k < 40; k++) begin
            si.push_back((k % 2) ? 8'hFF : 8'h00);
            sq.push_back((k % 2) ? 8'h00 : 8'hFF);
        end
        // Opposite ramps on the two channels (R2).
        for (int k = 0; k < 40; k++) begin si.push_back(k * 6); sq.push_back(255 - k * 3); end
        // Random codes.
        for (int k = 0; k < 80; k++) begin
            si.push_back(int'($urandom_range(0, 255)));
            sq.push_back(int'($urandom_range(0, 255)));
        end
        // Three leftover pairs form a partial group (R8).
        for (int k = 0; k < 3; k++) begin si.push_back(8'hC0); sq.push_back(8'h10); end
        build_expected();

        repeat (5) @(negedge clk_core);
        checks++;
        if (mag_valid !== 1'b0 || mag_data !== '0) begin
            fails++;
            $display("FAIL R1 reset state: got valid=%0d data=%0d expected 0/0", mag_valid, mag_data);
        end
        rst_n = 1'b1;
        repeat (5) @(negedge clk_core);
        checks++;
        if (mag_valid !== 1'b0 || mag_data !== '0) begin
            fails++;
            $display("FAIL R1 after reset: got valid=%0d data=%0d expected 0/0", mag_valid, mag_data);
        end

        // Two rising edges release the capture reset; those pairs are discarded (R2).
        send_pair(8'h80, 8'h80);
        send_pair(8'h80, 8'h80);
        for (int k = 0; k < si.size(); k++) send_pair(si[k], sq[k]);
        // Trailing edge pushes the last real pair into the FIFO.
        send_pair(8'h80, 8'h80);
        repeat (300) @(negedge clk_core);

        // R4 and R8: every group delivered once, the partial group never.
        checks++;
        if (seen != n_expected || exp_q.size() != 0) begin
            fails++;
            $display("FAIL R4 R8 output count: got %0d expected %0d", seen, n_expected);
        end
        summary();
        $finish;
    end

endmodule